// File: doc/BRIEF.md
# Sequential 3x3 Convolution Engine

The engine computes a 3x3 convolution over a multi-channel feature map with one shared multiplier-accumulator. Activations and weights are held in two on-chip memories with synchronous read, and both are filled through plain write ports before a run. A one-cycle `start` pulse starts the computation. The engine then steps through a six-level counter nest and issues exactly one multiply-accumulate per clock. Each finished pixel sum leaves on a result write port as a 32-bit value with its channel, row and column. A one-cycle `done` pulse closes the run.

Only interior pixels are computed. Rows and columns 0 and IMG_DIM-1 are skipped rather than padded, so the engine never writes them.

The control is a five-state machine:
- `ST_IDLE` waits for `start` (transition IDLE→RUN).
- `ST_RUN` issues one memory read and one MAC step per cycle. It leaves for `ST_FLUSH_A` on the final step (RUN→FLUSH_A).
- `ST_FLUSH_A` and `ST_FLUSH_B` let the two-stage read/accumulate pipeline empty (FLUSH_A→FLUSH_B→DONE).
- `ST_DONE` raises `done` for one cycle and returns to idle (DONE→IDLE).

Top module: `conv_seq_engine`

## Requirements
- R1: Activations and weights are signed 8-bit (two's complement). A result is the signed 32-bit sum of the sign-extended 16-bit products. Activation address = (ci*IMG_DIM + y)*IMG_DIM + x. Weight address = ((co*N_IN + ci)*3 + ky)*3 + kx.
- R2: The result for (co, y, x) equals the sum over ci, ky, kx of act[ci][y+ky-1][x+kx-1] * wgt[co][ci][ky][kx].
- R3: Results are written once per interior pixel, in this order: co outermost, then y, then x. The inner walk per pixel is ci, then ky, then kx, so writes are exactly N_IN*9 cycles apart.
- R4: No write ever carries y or x equal to 0 or IMG_DIM-1.
- R5: The accumulator restarts from the first product of each pixel, so no sum carries into the next pixel.
- R6: Counting from the clock edge that samples `start`, the write for the i-th pixel (i from 0) is visible after (i+1)*N_IN*9+1 further edges.
- R7: `done` is high for exactly one cycle, the cycle after the final result write.
- R8: A `start` received while the engine is not in `ST_IDLE` is ignored and does not disturb the run.
- R9: After reset, `done` and `out_we` are low and no write occurs until `start`.
- R10: A new `start` after `done` runs again on the current memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| act_we | input | 1 | Activation memory write enable |
| act_waddr | input | ACT_AW | Activation memory write address |
| act_wdata | input | 8 | Activation value to store |
| wgt_we | input | 1 | Weight memory write enable |
| wgt_waddr | input | WGT_AW | Weight memory write address |
| wgt_wdata | input | 8 | Weight value to store |
| done | output | 1 | One-cycle end-of-run pulse |
| out_we | output | 1 | Result write strobe |
| out_co | output | CO_W | Output channel of the result |
| out_y | output | POS_W | Row of the result |
| out_x | output | POS_W | Column of the result |
| out_data | output | 32 | Signed 32-bit result |

## Verification
The bench records the edge count at which `start` is sampled. It then gives every expected pixel its exact due cycle: (i+1)*N_IN*9+1 edges later, with `done` due one edge after the final write. The monitor samples on falling edges. It compares each write against the head of the queue for coordinates, value and cycle, so any early, late, extra or reordered write fails. A `start` pulse injected in the middle of a run must leave that whole schedule unchanged.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int KSIZE = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH_A,
        ST_FLUSH_B,
        ST_DONE
    } eng_state_t;

    // Counter/address width for a range of n values, never below one bit.
    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/conv_sp_mem.sv
module conv_sp_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/conv_loop_ctrl.sv
module conv_loop_ctrl
    import conv_seq_pkg::*;
#(
    parameter int IMG   = 16,
    parameter int CIN   = 4,
    parameter int COUT  = 4,
    parameter int CO_W  = 2,
    parameter int CI_W  = 2,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             issue,
    output logic             tap_first,
    output logic             tap_last,
    output logic             done,
    output logic [CO_W-1:0]  co,
    output logic [POS_W-1:0] y,
    output logic [POS_W-1:0] x,
    output logic [CI_W-1:0]  ci,
    output logic [1:0]       ky,
    output logic [1:0]       kx
);

    eng_state_t state, state_nx;

    logic kx_end, ky_end, ci_end, x_end, y_end, co_end, final_step;

    assign kx_end     = (kx == 2'd2);
    assign ky_end     = (ky == 2'd2);
    assign ci_end     = (ci == CI_W'(CIN - 1));
    assign x_end      = (x == POS_W'(IMG - 2));
    assign y_end      = (y == POS_W'(IMG - 2));
    assign co_end     = (co == CO_W'(COUT - 1));
    assign tap_first  = (kx == 2'd0) && (ky == 2'd0) && (ci == '0);
    assign tap_last   = kx_end && ky_end && ci_end;
    assign final_step = tap_last && x_end && y_end && co_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_RUN;
            ST_RUN:     if (final_step) state_nx = ST_FLUSH_A;
            ST_FLUSH_A: state_nx = ST_FLUSH_B;
            ST_FLUSH_B: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        issue = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_RUN:  issue = 1'b1;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
    end

    // Six-level loop nest: co > y > x > ci > ky > kx
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            co <= '0;
            y  <= POS_W'(1);
            x  <= POS_W'(1);
            ci <= '0;
            ky <= '0;
            kx <= '0;
        end else if (state == ST_IDLE && start) begin
            co <= '0;
            y  <= POS_W'(1);
            x  <= POS_W'(1);
            ci <= '0;
            ky <= '0;
            kx <= '0;
        end else if (state == ST_RUN && !final_step) begin
            if (!kx_end) begin
                kx <= kx + 2'd1;
            end else begin
                kx <= '0;
                if (!ky_end) begin
                    ky <= ky + 2'd1;
                end else begin
                    ky <= '0;
                    if (!ci_end) begin
                        ci <= ci + CI_W'(1);
                    end else begin
                        ci <= '0;
                        if (!x_end) begin
                            x <= x + POS_W'(1);
                        end else begin
                            x <= POS_W'(1);
                            if (!y_end) begin
                                y <= y + POS_W'(1);
                            end else begin
                                y  <= POS_W'(1);
                                co <= co + CO_W'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    // R8: a start seen mid-run must not rewind the nest to its first step
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && start) |=> !(tap_first && co == '0 && y == POS_W'(1) && x == POS_W'(1)));

endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
    parameter int CO_W  = 2,
    parameter int POS_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic                in_last,
    input  logic [7:0]          a,
    input  logic [7:0]          b,
    input  logic [CO_W-1:0]     in_co,
    input  logic [POS_W-1:0]    in_y,
    input  logic [POS_W-1:0]    in_x,
    output logic                wr_en,
    output logic [CO_W-1:0]     wr_co,
    output logic [POS_W-1:0]    wr_y,
    output logic [POS_W-1:0]    wr_x,
    output logic signed [31:0]  acc
);

    logic signed [15:0] prod;
    logic signed [31:0] prod_ext;

    assign prod     = $signed(a) * $signed(b);
    assign prod_ext = {{16{prod[15]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            wr_en <= 1'b0;
            wr_co <= '0;
            wr_y  <= '0;
            wr_x  <= '0;
        end else begin
            wr_en <= in_valid && in_last;
            if (in_valid) begin
                acc <= in_first ? prod_ext : (acc + prod_ext);
            end
            if (in_valid && in_last) begin
                wr_co <= in_co;
                wr_y  <= in_y;
                wr_x  <= in_x;
            end
        end
    end

endmodule

// File: rtl/conv_seq_engine.sv
module conv_seq_engine
    import conv_seq_pkg::*;
#(
    parameter  int IMG_DIM = 16,
    parameter  int N_IN    = 4,
    parameter  int N_OUT   = 4,
    localparam int ACT_N   = N_IN * IMG_DIM * IMG_DIM,
    localparam int WGT_N   = N_OUT * N_IN * KSIZE * KSIZE,
    localparam int ACT_AW  = cw(ACT_N),
    localparam int WGT_AW  = cw(WGT_N),
    localparam int CO_W    = cw(N_OUT),
    localparam int CI_W    = cw(N_IN),
    localparam int POS_W   = cw(IMG_DIM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               act_we,
    input  logic [ACT_AW-1:0]  act_waddr,
    input  logic [7:0]         act_wdata,
    input  logic               wgt_we,
    input  logic [WGT_AW-1:0]  wgt_waddr,
    input  logic [7:0]         wgt_wdata,
    output logic               done,
    output logic               out_we,
    output logic [CO_W-1:0]    out_co,
    output logic [POS_W-1:0]   out_y,
    output logic [POS_W-1:0]   out_x,
    output logic signed [31:0] out_data
);

    logic             issue, tap_first, tap_last;
    logic [CO_W-1:0]  co;
    logic [POS_W-1:0] y, x;
    logic [CI_W-1:0]  ci;
    logic [1:0]       ky, kx;

    logic [ACT_AW-1:0] act_raddr;
    logic [WGT_AW-1:0] wgt_raddr;
    logic [7:0]        act_q, wgt_q;

    logic             v1, first1, last1;
    logic [CO_W-1:0]  co1;
    logic [POS_W-1:0] y1, x1;

    conv_loop_ctrl #(
        .IMG(IMG_DIM), .CIN(N_IN), .COUT(N_OUT),
        .CO_W(CO_W), .CI_W(CI_W), .POS_W(POS_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .issue(issue), .tap_first(tap_first), .tap_last(tap_last), .done(done),
        .co(co), .y(y), .x(x), .ci(ci), .ky(ky), .kx(kx)
    );

    // Address generation: window tap (y+ky-1, x+kx-1) and matching weight
    always_comb begin
        int row;
        int col;
        row       = int'(y) + int'(ky) - 1;
        col       = int'(x) + int'(kx) - 1;
        act_raddr = ACT_AW'((int'(ci) * IMG_DIM + row) * IMG_DIM + col);
        wgt_raddr = WGT_AW'(((int'(co) * N_IN + int'(ci)) * KSIZE + int'(ky)) * KSIZE + int'(kx));
    end

    conv_sp_mem #(.DEPTH(ACT_N), .WIDTH(8), .AW(ACT_AW)) u_act_mem (
        .clk(clk), .we(act_we), .waddr(act_waddr), .wdata(act_wdata),
        .raddr(act_raddr), .rdata(act_q)
    );

    conv_sp_mem #(.DEPTH(WGT_N), .WIDTH(8), .AW(WGT_AW)) u_wgt_mem (
        .clk(clk), .we(wgt_we), .waddr(wgt_waddr), .wdata(wgt_wdata),
        .raddr(wgt_raddr), .rdata(wgt_q)
    );

    // Step tags travel alongside the synchronous read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            first1 <= 1'b0;
            last1  <= 1'b0;
            co1    <= '0;
            y1     <= '0;
            x1     <= '0;
        end else begin
            v1     <= issue;
            first1 <= tap_first;
            last1  <= tap_last;
            co1    <= co;
            y1     <= y;
            x1     <= x;
        end
    end

    conv_mac #(.CO_W(CO_W), .POS_W(POS_W)) u_mac (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v1), .in_first(first1), .in_last(last1),
        .a(act_q), .b(wgt_q),
        .in_co(co1), .in_y(y1), .in_x(x1),
        .wr_en(out_we), .wr_co(out_co), .wr_y(out_y), .wr_x(out_x),
        .acc(out_data)
    );

    // R4: border rows and columns are never written
    assert_border_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_y >= POS_W'(1) && out_y <= POS_W'(IMG_DIM - 2) &&
                    out_x >= POS_W'(1) && out_x <= POS_W'(IMG_DIM - 2)));

    // R3: a pixel takes at least nine MAC steps, so writes never sit back to back
    assert_write_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> !out_we);

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows the final write by one cycle
    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_we));

endmodule

// File: tb/conv_seq_engine_bench.sv
module conv_seq_engine_bench;
    import conv_seq_pkg::*;

    localparam int IMG    = 6;
    localparam int CIN    = 2;
    localparam int COUT   = 2;
    localparam int TAPS   = CIN * 9;
    localparam int NPIX   = COUT * (IMG - 2) * (IMG - 2);
    localparam int ACT_N  = CIN * IMG * IMG;
    localparam int WGT_N  = COUT * CIN * 9;
    localparam int ACT_AW = cw(ACT_N);
    localparam int WGT_AW = cw(WGT_N);
    localparam int CO_W   = cw(COUT);
    localparam int POS_W  = cw(IMG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              act_we = 1'b0;
    logic [ACT_AW-1:0] act_waddr = '0;
    logic [7:0]        act_wdata = '0;
    logic              wgt_we = 1'b0;
    logic [WGT_AW-1:0] wgt_waddr = '0;
    logic [7:0]        wgt_wdata = '0;
    logic              done, out_we;
    logic [CO_W-1:0]   out_co;
    logic [POS_W-1:0]  out_y, out_x;
    logic signed [31:0] out_data;

    conv_seq_engine #(.IMG_DIM(IMG), .N_IN(CIN), .N_OUT(COUT)) u_conv_seq_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .act_we(act_we), .act_waddr(act_waddr), .act_wdata(act_wdata),
        .wgt_we(wgt_we), .wgt_waddr(wgt_waddr), .wgt_wdata(wgt_wdata),
        .done(done), .out_we(out_we), .out_co(out_co), .out_y(out_y), .out_x(out_x),
        .out_data(out_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int co;
        int y;
        int x;
        int val;
        int due;
    } exp_t;

    exp_t q[$];
    int   act_g[ACT_N];
    int   wgt_g[WGT_N];
    int   n_chk = 0;
    int   n_fail = 0;
    int   done_due = -1;
    int   writes_seen = 0;
    bit   done_seen = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: pop and compare every write against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_we) begin
                writes_seen++;
                check(int'(out_y) >= 1 && int'(out_y) <= IMG - 2 &&
                      int'(out_x) >= 1 && int'(out_x) <= IMG - 2,
                      "R4", "border write row*16+col", int'(out_y) * 16 + int'(out_x), -1);
                if (q.size() == 0) begin
                    check(1'b0, "R9", "unexpected write at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(int'(out_co) == e.co, "R3", "channel order", int'(out_co), e.co);
                    check(int'(out_y) == e.y, "R3", "row order", int'(out_y), e.y);
                    check(int'(out_x) == e.x, "R3", "column order", int'(out_x), e.x);
                    check(out_data == e.val, "R2", "pixel sum", out_data, e.val);
                    check(cyc == e.due, "R6", "write cycle", cyc, e.due);
                end
            end
            if (done) begin
                check(cyc == done_due, "R7", "done cycle", cyc, done_due);
                check(q.size() == 0, "R7", "results pending at done", q.size(), 0);
                done_seen = 1'b1;
            end
        end
    end

    function automatic int gen(input int kind, input int idx, input int is_w, input int seed);
        case (kind)
            1:       return -128;
            2:       return (is_w != 0) ? -128 : 127;
            default: return ((idx * 73 + is_w * 41 + seed * 29 + 11) % 256) - 128;
        endcase
    endfunction

    // Driver: load memories, launch, push expected items with their due cycles
    task automatic run_case(input int kind, input int seed, input bit poke_start, input string tag);
        int st;
        int idx;
        for (int a = 0; a < ACT_N; a++) begin
            @(negedge clk);
            act_g[a]  = gen(kind, a, 0, seed);
            act_we    = 1'b1;
            act_waddr = ACT_AW'(a);
            act_wdata = 8'(act_g[a]);
        end
        for (int w = 0; w < WGT_N; w++) begin
            @(negedge clk);
            act_we    = 1'b0;
            wgt_g[w]  = gen(kind, w, 1, seed);
            wgt_we    = 1'b1;
            wgt_waddr = WGT_AW'(w);
            wgt_wdata = 8'(wgt_g[w]);
        end
        @(negedge clk);
        wgt_we      = 1'b0;
        writes_seen = 0;
        done_seen   = 1'b0;
        start       = 1'b1;
        @(posedge clk);
        #1;
        st  = cyc;
        idx = 0;
        for (int co = 0; co < COUT; co++)
            for (int y = 1; y <= IMG - 2; y++)
                for (int x = 1; x <= IMG - 2; x++) begin
                    exp_t e;
                    int   s;
                    s = 0;
                    for (int ci = 0; ci < CIN; ci++)
                        for (int ky = 0; ky < 3; ky++)
                            for (int kx = 0; kx < 3; kx++)
                                s += act_g[(ci * IMG + y + ky - 1) * IMG + x + kx - 1] *
                                     wgt_g[((co * CIN + ci) * 3 + ky) * 3 + kx];
                    e.co  = co;
                    e.y   = y;
                    e.x   = x;
                    e.val = s;
                    e.due = st + (idx + 1) * TAPS + 1;
                    q.push_back(e);
                    idx++;
                end
        done_due = st + NPIX * TAPS + 2;
        @(negedge clk);
        start = 1'b0;
        if (poke_start) begin
            // R8: a second start in the middle of the run must change nothing
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 4000 && !done_seen; t++) @(negedge clk);
        check(done_seen, tag, "done observed", int'(done_seen), 1);
        check(writes_seen == NPIX, "R3", "write count", writes_seen, NPIX);
        repeat (3) @(negedge clk);
        check(!done && !out_we, "R7", "quiet after done", int'(done) + int'(out_we), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done, "R9", "done after reset", int'(done), 0);
        check(!out_we, "R9", "out_we after reset", int'(out_we), 0);
        repeat (5) @(negedge clk);
        check(!out_we && !done, "R9", "idle without start", int'(out_we), 0);

        run_case(0, 1, 1'b0, "R2");   // R2/R5 mixed-sign pattern
        run_case(1, 0, 1'b0, "R1");   // R1 both operands -128: large positive sums
        run_case(2, 0, 1'b1, "R8");   // R1 127 x -128 negative sums, R8 start mid-run
        run_case(0, 7, 1'b0, "R10");  // R10/R5 relaunch with new contents
        report();
    end

endmodule